// File: doc/BRIEF.md
# ADC Status and Interrupt Controller

This block collects the events of a two-channel converter subsystem, with a primary and an auxiliary channel, into one status byte. It also keeps an 8-bit interrupt enable byte and drives a single interrupt line. The converters pass in completion strobes, signed result words, a calibration-complete strobe, overrange detector samples and configuration levels. The block latches the results into two data registers and raises sticky flags for result ready, threshold exceeded and overrange. A mirrored flag follows an external accumulator-comparator status input.

Software reaches the block through a plain synchronous port. A one-cycle read or write strobe carries a 2-bit address. Read data appears one cycle after the strobe, and any clear caused by the read takes effect at that same edge. The converter side has no back-pressure: every strobe is a single-cycle event that is always accepted, so the interface has no ready signal. Address map: 0 is the status byte (read only), 1 is the enable byte, 2 is the primary data register and 3 is the auxiliary data register. Data reads are sign-extended to the bus width.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset the status byte, the enable byte and `irq` are all zero.
- R2: The enable byte at address 1 reads back what was written, with bits 2, 5 and 7 forced to zero. Those bits also read as zero in the status byte.
- R3: Status bit 0 sets on `p_done` or `cal_done`. A read of address 2 clears it, and that read returns the last primary result sign-extended to 32 bits.
- R4: Status bit 1 sets on `a_done` or `cal_done`. It clears only when a read of address 3 is followed later by a read of address 2. A read of address 2 with no earlier read of address 3 leaves it set.
- R5: When a set event and a clearing read reach the same ready flag in the same cycle, the flag stays set.
- R6: Status bit 4 is updated on every `p_done` while `cmp_en` is high, and the result is an unsigned comparison. It becomes 1 when the absolute value of `p_result` is strictly greater than `thresh`, and 0 otherwise. It is held at 0 while `cmp_en` is low.
- R7: With `cnt_en` high, bit 4 sets only on the conversion at which the run of consecutive exceeding conversions reaches `cnt_limit`. A conversion that does not exceed the threshold restarts the run from zero. The run count saturates at `cnt_limit`.
- R8: Status bit 3 sets on a cycle with `ovr_tick`, `ovr_en` and `ovr_det` all high. An overrange sample without a tick has no effect. Once set, the bit stays set until `ovr_en` goes low or `gain_wr` pulses. A set in the same cycle as `gain_wr` wins.
- R9: Status bit 6 follows `acc_thex` one cycle later.
- R10: `irq` is high in the cycle after any status bit is set while its enable bit is set, and low in the cycle after no such pair exists.
- R11: Writes to addresses 0, 2 and 3 change neither the status byte nor the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_done | input | 1 | Primary conversion complete strobe |
| p_result | input | 24 | Primary signed result, valid with `p_done` |
| a_done | input | 1 | Auxiliary conversion complete strobe |
| a_result | input | 24 | Auxiliary signed result, valid with `a_done` |
| cal_done | input | 1 | Calibration sequence complete strobe |
| cmp_en | input | 1 | Threshold comparator enable |
| cnt_en | input | 1 | Threshold run-count qualifier enable |
| thresh | input | 24 | Unsigned magnitude threshold |
| cnt_limit | input | 8 | Required run length of exceeding conversions |
| ovr_en | input | 1 | Overrange detection enable (configuration bit 2) |
| ovr_tick | input | 1 | Periodic overrange evaluation tick |
| ovr_det | input | 1 | Raw overrange detector level |
| gain_wr | input | 1 | Gain-change write strobe |
| acc_thex | input | 1 | Accumulator comparator status level |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a new primary result and a clearing read of address 2. The second is an overrange tick and a gain-change write. The bench drives each pair of strobes from the same falling edge, so the design sees both at a single rising edge. It then reads the status byte and expects the flag to be set, because the set wins. A second status read, after the clear has acted, shows the flag's next state.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_RDY_P = 0;
  localparam int BIT_RDY_A = 1;
  localparam int BIT_OVR   = 3;
  localparam int BIT_THX   = 4;
  localparam int BIT_ACC   = 6;
  localparam logic [STAT_W-1:0] LIVE_BITS =
    STAT_W'((1 << BIT_RDY_P) | (1 << BIT_RDY_A) | (1 << BIT_OVR) |
            (1 << BIT_THX) | (1 << BIT_ACC));
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_PDAT = 2'd2,
    REG_ADAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/adc_rdy_unit.sv
module adc_rdy_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic p_done_i,
  input  logic a_done_i,
  input  logic cal_done_i,
  input  logic rd_pdat_i,
  input  logic rd_adat_i,
  output logic rdy_p_o,
  output logic rdy_a_o
);
  logic aux_seen;
  logic set_p, set_a, clr_a;

  assign set_p = p_done_i | cal_done_i;
  assign set_a = a_done_i | cal_done_i;
  assign clr_a = rd_pdat_i & aux_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_p_o  <= 1'b0;
      rdy_a_o  <= 1'b0;
      aux_seen <= 1'b0;
    end else begin
      if (set_p)          rdy_p_o <= 1'b1;
      else if (rd_pdat_i) rdy_p_o <= 1'b0;
      if (set_a)          rdy_a_o <= 1'b1;
      else if (clr_a)     rdy_a_o <= 1'b0;
      if (rd_adat_i)      aux_seen <= 1'b1;
      else if (rd_pdat_i) aux_seen <= 1'b0;
    end
  end

  p_set_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
    p_done_i |=> rdy_p_o);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_p && rd_pdat_i) |=> rdy_p_o);
  p_aux_needs_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_a_o && rd_pdat_i && !aux_seen) |=> rdy_a_o);
endmodule

// File: rtl/adc_thresh_unit.sv
module adc_thresh_unit #(
  parameter int RES_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic [RES_W-1:0] result_i,
  input  logic [RES_W-1:0] thresh_i,
  input  logic             cmp_en_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             thex_o
);
  logic [RES_W-1:0] mag;
  logic             over;
  logic [CNT_W-1:0] run, run_nxt;

  assign mag     = result_i[RES_W-1] ? (~result_i + 1'b1) : result_i;
  assign over    = mag > thresh_i;
  assign run_nxt = (run >= limit_i) ? limit_i : run + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !cmp_en_i) begin
      run    <= '0;
      thex_o <= 1'b0;
    end else if (conv_i) begin
      if (!over) begin
        run    <= '0;
        thex_o <= 1'b0;
      end else begin
        run    <= run_nxt;
        thex_o <= cnt_en_i ? (run_nxt == limit_i) : 1'b1;
      end
    end
  end

  p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_i |=> !thex_o);
  p_below_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_i && conv_i && !over) |=> !thex_o);
endmodule

// File: rtl/adc_ovr_unit.sv
module adc_ovr_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic det_i,
  input  logic gain_wr_i,
  output logic ovr_o
);
  logic hit;
  assign hit = en_i & tick_i & det_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                 ovr_o <= 1'b0;
    else if (hit)               ovr_o <= 1'b1;
    else if (!en_i || gain_wr_i) ovr_o <= 1'b0;
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && en_i && !gain_wr_i) |=> ovr_o);
  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_o && !tick_i) |=> !ovr_o);
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
  import adc_irq_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int CNT_W = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_done,
  input  logic [RES_W-1:0] p_result,
  input  logic             a_done,
  input  logic [RES_W-1:0] a_result,
  input  logic             cal_done,
  input  logic             cmp_en,
  input  logic             cnt_en,
  input  logic [RES_W-1:0] thresh,
  input  logic [CNT_W-1:0] cnt_limit,
  input  logic             ovr_en,
  input  logic             ovr_tick,
  input  logic             ovr_det,
  input  logic             gain_wr,
  input  logic             acc_thex,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int EXT_W = BUS_W - RES_W;

  logic [RES_W-1:0]  p_data, a_data;
  logic [STAT_W-1:0] mask, status;
  logic              rdy_p, rdy_a, thex, ovr, acc_q;
  logic              rd_pdat, rd_adat, wr_mask;
  logic [BUS_W-1:0]  rd_mux;

  assign rd_pdat = bus_rd && (reg_sel_e'(bus_addr) == REG_PDAT);
  assign rd_adat = bus_rd && (reg_sel_e'(bus_addr) == REG_ADAT);
  assign wr_mask = bus_wr && (reg_sel_e'(bus_addr) == REG_MASK);

  adc_rdy_unit u_rdy (
    .clk, .rst_n,
    .p_done_i(p_done), .a_done_i(a_done), .cal_done_i(cal_done),
    .rd_pdat_i(rd_pdat), .rd_adat_i(rd_adat),
    .rdy_p_o(rdy_p), .rdy_a_o(rdy_a)
  );

  adc_thresh_unit #(.RES_W(RES_W), .CNT_W(CNT_W)) u_thx (
    .clk, .rst_n,
    .conv_i(p_done), .result_i(p_result), .thresh_i(thresh),
    .cmp_en_i(cmp_en), .cnt_en_i(cnt_en), .limit_i(cnt_limit),
    .thex_o(thex)
  );

  adc_ovr_unit u_ovr (
    .clk, .rst_n,
    .en_i(ovr_en), .tick_i(ovr_tick), .det_i(ovr_det),
    .gain_wr_i(gain_wr), .ovr_o(ovr)
  );

  always_comb begin
    status            = '0;
    status[BIT_RDY_P] = rdy_p;
    status[BIT_RDY_A] = rdy_a;
    status[BIT_OVR]   = ovr;
    status[BIT_THX]   = thex;
    status[BIT_ACC]   = acc_q;
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_STAT: rd_mux = BUS_W'(status);
      REG_MASK: rd_mux = BUS_W'(mask);
      REG_PDAT: rd_mux = {{EXT_W{p_data[RES_W-1]}}, p_data};
      default:  rd_mux = {{EXT_W{a_data[RES_W-1]}}, a_data};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_data    <= '0;
      a_data    <= '0;
      mask      <= '0;
      acc_q     <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (p_done)  p_data <= p_result;
      if (a_done)  a_data <= a_result;
      if (wr_mask) mask   <= bus_wdata & LIVE_BITS;
      if (bus_rd)  bus_rdata <= rd_mux;
      acc_q <= acc_thex;
      irq   <= |(status & mask);
    end
  end

  p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == ($past(bus_wdata) & LIVE_BITS)));
  p_irq_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask)) |=> irq);
  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask)) |=> !irq);
  p_acc_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_thex |=> status[BIT_ACC]);
  p_data_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !p_done |=> $stable(p_data));
endmodule

// File: tb/sim_adc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic p_done = 0, a_done = 0, cal_done = 0, cmp_en = 0, cnt_en = 0;
  logic [23:0] p_result = '0, a_result = '0, thresh = '0;
  logic [7:0] cnt_limit = '0, bus_wdata = '0;
  logic ovr_en = 0, ovr_tick = 0, ovr_det = 0, gain_wr = 0, acc_thex = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  adc_irq_ctrl u0 (.*);

  // {result, threshold, expected bit 4}
  localparam logic [48:0] VEC [8] = '{
    {24'd100,     24'd99,      1'b1},
    {24'd99,      24'd99,      1'b0},
    {24'hFFFF9C,  24'd99,      1'b1},
    {24'hFFFF9D,  24'd99,      1'b0},
    {24'd0,       24'd0,       1'b0},
    {24'd1,       24'd0,       1'b1},
    {24'h800000,  24'h7FFFFF,  1'b1},
    {24'h7FFFFF,  24'h7FFFFF,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic conv(input logic [23:0] v);
    p_result = v; p_done = 1;
    @(negedge clk);
    p_done = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 0);
    rd_reg(0, rd); chk("R1 status", rd, 0);
    rd_reg(1, rd); chk("R1 mask", rd, 0);

    // threshold vectors, enable bit 4 only
    wr_reg(1, 8'h10);
    cmp_en = 1;
    for (int i = 0; i < 8; i++) begin
      thresh = VEC[i][24:1];
      conv(VEC[i][48:25]);
      @(negedge clk);
      chk("R10 irq per vector", {31'd0, irq}, {31'd0, VEC[i][0]});
      rd_reg(0, rd); chk("R6 bit4", {31'd0, rd[4]}, {31'd0, VEC[i][0]});
      rd_reg(2, rd); chk("R3 data sext", rd, {{8{VEC[i][48]}}, VEC[i][48:25]});
    end
    thresh = 24'd10;
    conv(24'd50);
    cmp_en = 0;
    @(negedge clk);
    rd_reg(0, rd); chk("R6 disabled clears", {31'd0, rd[4]}, 0);
    cmp_en = 1;

    // R7 run counter, limit 3
    cnt_en = 1; cnt_limit = 3;
    conv(24'd50); conv(24'd50);
    rd_reg(0, rd); chk("R7 two of three", {31'd0, rd[4]}, 0);
    conv(24'd5); conv(24'd50); conv(24'd50);
    rd_reg(0, rd); chk("R7 restart after miss", {31'd0, rd[4]}, 0);
    conv(24'd50);
    rd_reg(0, rd); chk("R7 reached limit", {31'd0, rd[4]}, 1);
    conv(24'd50);
    rd_reg(0, rd); chk("R7 saturated stays", {31'd0, rd[4]}, 1);
    cnt_en = 0; cmp_en = 0;
    rd_reg(2, rd);

    // R2 mask and reserved bits
    wr_reg(1, 8'hFF);
    rd_reg(1, rd); chk("R2 mask readback", rd, 32'h5B);

    // R3 / R5 ready and set-wins
    rd_reg(0, rd); chk("R3 bit0 clear", {31'd0, rd[0]}, 0);
    conv(24'd7);
    rd_reg(0, rd); chk("R3 bit0 set", {31'd0, rd[0]}, 1);
    p_result = 24'd8; p_done = 1; bus_rd = 1; bus_addr = 2;
    @(negedge clk);
    p_done = 0; bus_rd = 0;
    rd_reg(0, rd); chk("R5 set wins", {31'd0, rd[0]}, 1);
    rd_reg(2, rd); chk("R3 newest data", rd, 32'd8);
    rd_reg(0, rd); chk("R3 read clears", {31'd0, rd[0]}, 0);

    // R4 auxiliary sequence
    a_result = 24'hFFFFFE; a_done = 1;
    @(negedge clk);
    a_done = 0;
    rd_reg(2, rd);
    rd_reg(0, rd); chk("R4 primary alone keeps", {31'd0, rd[1]}, 1);
    rd_reg(3, rd); chk("R4 aux data", rd, 32'hFFFFFFFE);
    rd_reg(0, rd); chk("R4 aux alone keeps", {31'd0, rd[1]}, 1);
    rd_reg(2, rd);
    rd_reg(0, rd); chk("R4 sequence clears", {31'd0, rd[1]}, 0);
    cal_done = 1;
    @(negedge clk);
    cal_done = 0;
    rd_reg(0, rd); chk("R3 R4 calibration sets", rd & 32'h3, 32'h3);
    rd_reg(3, rd); rd_reg(2, rd);

    // R11 writes to status/data ignored
    wr_reg(0, 8'hFF); wr_reg(2, 8'h55);
    rd_reg(0, rd); chk("R11 status write ignored", rd, 0);
    rd_reg(2, rd); chk("R11 data write ignored", rd, 32'd8);

    // R8 overrange
    ovr_en = 1; ovr_det = 1;
    @(negedge clk);
    rd_reg(0, rd); chk("R8 no tick no set", {31'd0, rd[3]}, 0);
    ovr_tick = 1; @(negedge clk); ovr_tick = 0; ovr_det = 0;
    ovr_tick = 1; @(negedge clk); ovr_tick = 0;
    rd_reg(0, rd); chk("R8 sticky", {31'd0, rd[3]}, 1);
    gain_wr = 1; @(negedge clk); gain_wr = 0;
    rd_reg(0, rd); chk("R8 gain clears", {31'd0, rd[3]}, 0);
    ovr_det = 1; ovr_tick = 1; gain_wr = 1;
    @(negedge clk);
    ovr_tick = 0; gain_wr = 0; ovr_det = 0;
    rd_reg(0, rd); chk("R8 set beats gain", {31'd0, rd[3]}, 1);
    ovr_en = 0; @(negedge clk);
    rd_reg(0, rd); chk("R8 disable clears", {31'd0, rd[3]}, 0);

    // R9 / R10 accumulator and irq timing
    wr_reg(1, 8'h40);
    chk("R10 idle low", {31'd0, irq}, 0);
    acc_thex = 1;
    @(negedge clk);
    chk("R10 one cycle lag", {31'd0, irq}, 0);
    rd_reg(0, rd); chk("R9 mirror", rd, 32'h40);
    chk("R10 irq high", {31'd0, irq}, 1);
    acc_thex = 0;
    repeat (2) @(negedge clk);
    chk("R10 irq drops", {31'd0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule